// File: doc/BRIEF.md
# Status Flag Register Unit

This block keeps the five arithmetic status flags of a processor core (sign, zero, auxiliary carry, parity and carry) and carries out the small group of flag-only instructions whose operands are implied rather than named. Two of them move flags to and from the high byte of the accumulator: one packs the flags into a byte image, the other unpacks selected byte bits into the flags. Three act on the carry alone: clear it, set it, or invert it. Between instructions the ALU may overwrite all five flags with its own result.

The byte image has fixed positions. Sign sits at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Positions 1, 3 and 5 are reserved: they read back as 1, 0 and 0, and whatever the accumulator carries there is dropped on a store. When the core runs in its 64-bit mode, the two byte-transfer instructions are legal only if a feature-enable bit is set. Otherwise they leave everything unchanged and raise a one-cycle invalid-opcode fault. Outside that mode they are always legal.

The request comes either as a 3-bit code or as a 5-bit one-hot vector, picked by a parameter. All results are registered and appear one clock after the request.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous reset, active high, clears all five flags, the byte output, the byte write strobe and the fault output.
- R2: A legal store-byte request sets sign, zero, auxiliary carry, parity and carry from byte bits 7, 6, 4, 2 and 0. On flags_o the flags sit at bits 4 (sign), 3 (zero), 2 (aux), 1 (parity) and 0 (carry), and they update on the clock edge that samples the request.
- R3: On a store-byte request, byte bits 1, 3 and 5 have no effect on any flag.
- R4: A legal load-byte request drives acc_hi_out to {sign, zero, 0, aux, 0, parity, 1, carry}, bit 7 first, and pulses acc_hi_we high for one cycle per request. The flags stay unchanged.
- R5: Clear-carry forces carry to 0, set-carry forces it to 1 and complement-carry inverts it. The other four flags keep their values.
- R6: With long_mode=1 and xfer_en=0, a load-byte or store-byte request changes no flag, gives no write strobe, and pulses ud_fault high for exactly one cycle.
- R7: With long_mode=0, both byte-transfer requests are legal whatever xfer_en holds. With long_mode=1 and xfer_en=1 they are also legal.
- R8: When no instruction is requested and alu_upd=1, all five flags take the value of alu_flags, which uses the same bit order as flags_o.
- R9: When alu_upd=1 and an instruction is requested in the same cycle, the instruction decides the flags and alu_flags is ignored. This holds even when the instruction faults.
- R10: In encoded form (ONE_HOT=0), op_req takes these values: 1 load-byte, 2 store-byte, 3 clear-carry, 4 set-carry, 5 complement-carry, and any other value means no instruction. In one-hot form (ONE_HOT=1), bits 0 to 4 select the same five operations in that order, and a vector with zero bits set or with more than one bit set means no instruction.
- R11: The carry instructions never raise ud_fault, in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_req | input | REQ_W (3 or 5) | Instruction request, encoded or one-hot |
| acc_hi_in | input | 8 | Accumulator high byte, the implied source of store-byte |
| long_mode | input | 1 | Core is in 64-bit mode |
| xfer_en | input | 1 | Feature bit that permits byte transfers in 64-bit mode |
| alu_upd | input | 1 | ALU flag update request |
| alu_flags | input | 5 | ALU flag result {sign, zero, aux, parity, carry} |
| flags_o | output | 5 | Current flags {sign, zero, aux, parity, carry} |
| acc_hi_out | output | 8 | Flag image for the accumulator high byte |
| acc_hi_we | output | 1 | Write strobe for acc_hi_out |
| ud_fault | output | 1 | Invalid-opcode fault pulse |

## Verification
The bench builds two copies side by side. One uses the default encoded request (ONE_HOT=0) and the other the one-hot request (ONE_HOT=1). Both receive the same operation sequence and must give the same results, so both decoder variants face every flag path and every mode-gating case. The one-hot copy also gets vectors with more than one bit set, which only that form can express, and these must count as no instruction so that a concurrent ALU update goes through.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    localparam int FLAG_N   = 5;
    localparam int BYTE_W   = 8;
    localparam int CODE_W   = 3;
    localparam int OP_COUNT = 5;

    // fixed positions inside the accumulator byte image
    localparam int POS_S = 7;
    localparam int POS_Z = 6;
    localparam int POS_A = 4;
    localparam int POS_P = 2;
    localparam int POS_C = 0;
    localparam int POS_R1 = 1;
    localparam int POS_R3 = 3;
    localparam int POS_R5 = 5;

    typedef enum logic [CODE_W-1:0] {
        OP_NONE   = 3'd0,
        OP_LOADB  = 3'd1,
        OP_STOREB = 3'd2,
        OP_CLRC   = 3'd3,
        OP_SETC   = 3'd4,
        OP_CPLC   = 3'd5
    } op_e;

    // packed order gives sign at bit 4 down to carry at bit 0
    typedef struct packed {
        logic s;
        logic z;
        logic a;
        logic p;
        logic c;
    } flags_t;

    function automatic logic is_xfer(op_e op);
        return (op == OP_LOADB) || (op == OP_STOREB);
    endfunction

    function automatic logic is_carry_op(op_e op);
        return (op == OP_CLRC) || (op == OP_SETC) || (op == OP_CPLC);
    endfunction

endpackage

// File: rtl/sfu_op_decode.sv
module sfu_op_decode
    import sfu_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0,
    parameter int REQ_W   = ONE_HOT ? OP_COUNT : CODE_W
) (
    input  logic [REQ_W-1:0] req,
    output op_e              op
);

    generate
        if (ONE_HOT) begin : g_onehot
            always_comb begin
                op = OP_NONE;
                if ($countones(req) == 1) begin
                    for (int i = 0; i < OP_COUNT; i++) begin
                        if (req[i]) op = op_e'(CODE_W'(i + 1));
                    end
                end
            end
            // R10: a legal single-bit request never decodes to no-op
            always_comb begin
                if ($countones(req) == 1) a_r10_onehot_decodes: assert (op != OP_NONE);
            end
        end else begin : g_coded
            always_comb begin
                case (req)
                    3'd1:    op = OP_LOADB;
                    3'd2:    op = OP_STOREB;
                    3'd3:    op = OP_CLRC;
                    3'd4:    op = OP_SETC;
                    3'd5:    op = OP_CPLC;
                    default: op = OP_NONE;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/sfu_mode_gate.sv
module sfu_mode_gate
    import sfu_pkg::*;
(
    input  op_e  op,
    input  logic long_mode,
    input  logic xfer_en,
    output logic present,
    output logic exec,
    output logic fault
);

    logic blocked;

    always_comb begin
        present = (op != OP_NONE);
        blocked = is_xfer(op) && long_mode && !xfer_en;
        exec    = present && !blocked;
        fault   = blocked;
    end

    // R11: carry operations are legal in every mode
    always_comb begin
        if (is_carry_op(op)) a_r11_carry_never_faults: assert (!fault && exec);
    end

endmodule

// File: rtl/sfu_byte_map.sv
module sfu_byte_map
    import sfu_pkg::*;
(
    input  flags_t             flags,
    input  logic [BYTE_W-1:0]  byte_in,
    output logic [BYTE_W-1:0]  image,
    output flags_t             unpacked
);

    logic unused_rsv_bits;

    always_comb begin
        image         = '0;
        image[POS_S]  = flags.s;
        image[POS_Z]  = flags.z;
        image[POS_A]  = flags.a;
        image[POS_P]  = flags.p;
        image[POS_C]  = flags.c;
        image[POS_R1] = 1'b1;
        image[POS_R3] = 1'b0;
        image[POS_R5] = 1'b0;

        unpacked.s = byte_in[POS_S];
        unpacked.z = byte_in[POS_Z];
        unpacked.a = byte_in[POS_A];
        unpacked.p = byte_in[POS_P];
        unpacked.c = byte_in[POS_C];

        unused_rsv_bits = ^{byte_in[POS_R1], byte_in[POS_R3], byte_in[POS_R5]};
    end

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
    import sfu_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0,
    parameter int REQ_W   = ONE_HOT ? OP_COUNT : CODE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [REQ_W-1:0]    op_req,
    input  logic [BYTE_W-1:0]   acc_hi_in,
    input  logic                long_mode,
    input  logic                xfer_en,
    input  logic                alu_upd,
    input  logic [FLAG_N-1:0]   alu_flags,
    output logic [FLAG_N-1:0]   flags_o,
    output logic [BYTE_W-1:0]   acc_hi_out,
    output logic                acc_hi_we,
    output logic                ud_fault
);

    typedef struct packed {
        flags_t              flags;
        logic [BYTE_W-1:0]   acc;
        logic                we;
        logic                fault;
    } state_t;

    state_t             st_d, st_q;
    op_e                op;
    logic               present, exec, fault;
    logic [BYTE_W-1:0]  image;
    flags_t             unpacked;

    sfu_op_decode #(.ONE_HOT(ONE_HOT), .REQ_W(REQ_W)) u_dec (
        .req (op_req),
        .op  (op)
    );

    sfu_mode_gate u_gate (
        .op        (op),
        .long_mode (long_mode),
        .xfer_en   (xfer_en),
        .present   (present),
        .exec      (exec),
        .fault     (fault)
    );

    sfu_byte_map u_map (
        .flags    (st_q.flags),
        .byte_in  (acc_hi_in),
        .image    (image),
        .unpacked (unpacked)
    );

    always_comb begin
        st_d       = st_q;
        st_d.we    = 1'b0;
        st_d.fault = fault;
        if (present) begin
            if (exec) begin
                case (op)
                    OP_LOADB: begin
                        st_d.acc = image;
                        st_d.we  = 1'b1;
                    end
                    OP_STOREB: st_d.flags   = unpacked;
                    OP_CLRC:   st_d.flags.c = 1'b0;
                    OP_SETC:   st_d.flags.c = 1'b1;
                    OP_CPLC:   st_d.flags.c = ~st_q.flags.c;
                    default:   st_d.flags   = st_q.flags;
                endcase
            end
        end else if (alu_upd) begin
            st_d.flags = flags_t'(alu_flags);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flags_o    = st_q.flags;
    assign acc_hi_out = st_q.acc;
    assign acc_hi_we  = st_q.we;
    assign ud_fault   = st_q.fault;

    // R6: a faulted request leaves the flags as they were
    a_r6_fault_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        ud_fault |-> (flags_o == $past(flags_o)));

    // R6: a fault and a byte write never coincide
    a_r6_fault_no_write: assert property (@(posedge clk) disable iff (rst)
        !(ud_fault && acc_hi_we));

    // R4: a byte load does not disturb the flags
    a_r4_load_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        acc_hi_we |-> (flags_o == $past(flags_o)));

    // R4: the reserved image positions read 1, 0, 0
    a_r4_image_reserved: assert property (@(posedge clk) disable iff (rst)
        acc_hi_we |-> (acc_hi_out[POS_R1] && !acc_hi_out[POS_R3] && !acc_hi_out[POS_R5]));

    // R5: carry instructions leave the upper four flags alone
    a_r5_carry_only: assert property (@(posedge clk) disable iff (rst)
        is_carry_op(op) |=> $stable(flags_o[FLAG_N-1:1]));

    // R9: ALU data is not taken while an instruction is requested
    a_r9_instr_wins: assert property (@(posedge clk) disable iff (rst)
        (present && !exec) |=> $stable(flags_o));

endmodule

// File: tb/sim_status_flag_unit.sv
module sim_status_flag_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] op0;
    logic [4:0] op1;
    logic [7:0] acc_in;
    logic       lmode, xen, aupd;
    logic [4:0] aflg;

    logic [4:0] f0, f1;
    logic [7:0] o0, o1;
    logic       we0, we1, ud0, ud1;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    status_flag_unit u0 (
        .clk(clk), .rst(rst), .op_req(op0), .acc_hi_in(acc_in),
        .long_mode(lmode), .xfer_en(xen), .alu_upd(aupd), .alu_flags(aflg),
        .flags_o(f0), .acc_hi_out(o0), .acc_hi_we(we0), .ud_fault(ud0)
    );

    status_flag_unit #(.ONE_HOT(1'b1)) u1 (
        .clk(clk), .rst(rst), .op_req(op1), .acc_hi_in(acc_in),
        .long_mode(lmode), .xfer_en(xen), .alu_upd(aupd), .alu_flags(aflg),
        .flags_o(f1), .acc_hi_out(o1), .acc_hi_we(we1), .ud_fault(ud1)
    );

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] acc;
        logic       lm;
        logic       en;
        logic       au;
        logic [4:0] af;
        logic [4:0] ef;
        logic       eud;
        logic       ewe;
        logic [7:0] eout;
    } vec_t;

    // op: 1 load, 2 store, 3 clear C, 4 set C, 5 complement C
    localparam vec_t TBL [19] = '{
        '{3'd2, 8'hFF, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b11111, 1'b0, 1'b0, 8'h00}, // R2 R7
        '{3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b11111, 1'b0, 1'b1, 8'hD7}, // R4
        '{3'd2, 8'h2A, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, 1'b0, 1'b0, 8'h00}, // R3
        '{3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, 1'b0, 1'b1, 8'h02}, // R4
        '{3'd4, 8'h00, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00001, 1'b0, 1'b0, 8'h00}, // R5
        '{3'd5, 8'h00, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, 1'b0, 1'b0, 8'h00}, // R5
        '{3'd5, 8'h00, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00001, 1'b0, 1'b0, 8'h00}, // R5
        '{3'd3, 8'h00, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, 1'b0, 1'b0, 8'h00}, // R5
        '{3'd2, 8'h91, 1'b1, 1'b1, 1'b0, 5'b00000, 5'b10101, 1'b0, 1'b0, 8'h00}, // R7
        '{3'd2, 8'h00, 1'b1, 1'b0, 1'b0, 5'b00000, 5'b10101, 1'b1, 1'b0, 8'h00}, // R6
        '{3'd1, 8'h00, 1'b1, 1'b0, 1'b0, 5'b00000, 5'b10101, 1'b1, 1'b0, 8'h00}, // R6
        '{3'd1, 8'h00, 1'b1, 1'b1, 1'b0, 5'b00000, 5'b10101, 1'b0, 1'b1, 8'h93}, // R7 R4
        '{3'd3, 8'h00, 1'b1, 1'b0, 1'b0, 5'b00000, 5'b10100, 1'b0, 1'b0, 8'h00}, // R11
        '{3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 5'b01010, 5'b01010, 1'b0, 1'b0, 8'h00}, // R8
        '{3'd5, 8'h00, 1'b0, 1'b0, 1'b1, 5'b11111, 5'b01011, 1'b0, 1'b0, 8'h00}, // R9
        '{3'd2, 8'h00, 1'b1, 1'b0, 1'b1, 5'b00000, 5'b01011, 1'b1, 1'b0, 8'h00}, // R9 faulted
        '{3'd7, 8'h00, 1'b0, 1'b0, 1'b1, 5'b10000, 5'b10000, 1'b0, 1'b0, 8'h00}, // R10 R8
        '{3'd2, 8'h55, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b01111, 1'b0, 1'b0, 8'h00}, // R2 R3
        '{3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b01111, 1'b0, 1'b1, 8'h57}  // R4 R7
    };

    function automatic logic [4:0] to_onehot(logic [2:0] c);
        if (c >= 3'd1 && c <= 3'd5) return 5'(1) << (c - 3'd1);
        return 5'b0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_both(string req, logic [4:0] ef, logic eud, logic ewe, logic [7:0] eout);
        chk({req, " flags u0"}, 32'(f0), 32'(ef));
        chk({req, " flags u1"}, 32'(f1), 32'(ef));
        chk({req, " fault u0"}, 32'(ud0), 32'(eud));
        chk({req, " fault u1"}, 32'(ud1), 32'(eud));
        chk({req, " we u0"}, 32'(we0), 32'(ewe));
        chk({req, " we u1"}, 32'(we1), 32'(ewe));
        if (ewe) begin
            chk({req, " byte u0"}, 32'(o0), 32'(eout));
            chk({req, " byte u1"}, 32'(o1), 32'(eout));
        end
    endtask

    task automatic idle();
        op0 = 3'd0; op1 = 5'b0; aupd = 1'b0; aflg = 5'b0;
        acc_in = 8'h00; lmode = 1'b0; xen = 1'b0;
    endtask

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk_both("R1 reset", 5'b0, 1'b0, 1'b0, 8'h00);
        chk("R1 byte after reset", 32'(o0), 32'h0);
        rst = 1'b0;

        foreach (TBL[i]) begin
            op0 = TBL[i].op; op1 = to_onehot(TBL[i].op);
            acc_in = TBL[i].acc; lmode = TBL[i].lm; xen = TBL[i].en;
            aupd = TBL[i].au; aflg = TBL[i].af;
            @(posedge clk); #1;
            chk_both($sformatf("table row %0d", i), TBL[i].ef, TBL[i].eud, TBL[i].ewe, TBL[i].eout);
        end

        // R4: one-cycle write strobe after a load
        idle(); op0 = 3'd1; op1 = 5'b00001;
        @(posedge clk); #1;
        chk_both("R4 load", 5'b01111, 1'b0, 1'b1, 8'h57);
        idle();
        @(posedge clk); #1;
        chk_both("R4 strobe drops", 5'b01111, 1'b0, 1'b0, 8'h00);

        // R6: fault lasts exactly one cycle
        idle(); op0 = 3'd2; op1 = 5'b00010; acc_in = 8'h00; lmode = 1'b1;
        @(posedge clk); #1;
        chk_both("R6 fault", 5'b01111, 1'b1, 1'b0, 8'h00);
        idle();
        @(posedge clk); #1;
        chk_both("R6 fault drops", 5'b01111, 1'b0, 1'b0, 8'h00);

        // R10: multi-bit one-hot is no instruction, so the ALU update lands
        idle(); op1 = 5'b00011; aupd = 1'b1; aflg = 5'b00110;
        @(posedge clk); #1;
        chk_both("R10 multi-hot", 5'b00110, 1'b0, 1'b0, 8'h00);

        // R3: reserved byte bits alone change nothing
        idle(); op0 = 3'd2; op1 = 5'b00010; acc_in = 8'h2A;
        @(posedge clk); #1;
        chk_both("R3 reserved only", 5'b00000, 1'b0, 1'b0, 8'h00);

        // R1: reset after activity
        idle(); aupd = 1'b1; aflg = 5'b11111;
        @(posedge clk); #1;
        idle(); rst = 1'b1;
        @(posedge clk); #1;
        chk_both("R1 reset again", 5'b0, 1'b0, 1'b0, 8'h00);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule